// File: doc/BRIEF.md
# Interrupt Line Acceptance and End-of-Interrupt Tracking

This block watches a set of interrupt input lines and decides when each one should produce an interrupt message. Every pin has a routing entry that software writes through a simple one-cycle write port. The entry holds a vector, a destination, an input polarity, a trigger mode (edge or level) and a mask. For each pin the block keeps a pending bit that follows the line's effective level. It also keeps, for each pin, either a queued edge request or a level-in-service flag (remote-IRR). Pins that need service are sent one at a time through a registered valid/ready delivery port. When several pins compete, the lowest-numbered pin goes first.

End-of-interrupt broadcasts arrive with a vector and a trigger mode. A level-mode EOI releases the in-service flag of every pin whose entry carries that vector. A pin whose line is still active is then offered again straight away. Events that cannot become a new delivery are reported as coalesced with a one-cycle pulse per pin.

Back-pressure rules for the delivery port: while `dlv_valid` is high and `dlv_ready` is low, the port holds its contents unchanged. A message leaves on a cycle where both are high, and the next winner may be loaded in that same cycle. The choice of a pin, and the bookkeeping it triggers, happens when the pin is loaded into the port, not when the message is accepted.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset `dlv_valid` and `coalesced` are low and every routing entry is masked, so active lines produce neither deliveries nor coalesced pulses until entries are written.
- R2: A pin's effective level is its line XOR the entry's polarity bit; with polarity 1 a low line counts as active.
- R3: An unmasked edge-mode pin is delivered once for each 0-to-1 change of its effective level. `dlv_valid` rises on the second clock edge after the change, provided the port is free. A level held active produces no further deliveries.
- R4: If an edge-mode pin sees a new 0-to-1 change while its earlier request has not yet been loaded into the port, the event is coalesced. `coalesced[pin]` pulses for one cycle and only one delivery results.
- R5: An unmasked level-mode pin whose pending bit is set is delivered when its remote-IRR is 0. Loading it into the port sets remote-IRR, and no further delivery of that pin happens while it stays set.
- R6: A level-mode pin whose effective level changes 0-to-1 while its remote-IRR is 1 pulses `coalesced[pin]` for one cycle. This pulse is visible after the clock edge that samples the change.
- R7: An EOI with `eoi_level`=1 clears remote-IRR on every pin whose vector equals `eoi_vector`. A pin that is still pending and unmasked is delivered again without any new line change. An EOI with `eoi_level`=0 leaves remote-IRR unchanged.
- R8: When the effective level drops, the pending bit clears, so an EOI arriving after the line went inactive produces no delivery.
- R9: A masked pin is never delivered and never reports coalesced events. Masking an edge-mode pin discards any request it had queued.
- R10: Writing a pin's routing entry clears its remote-IRR. A level-mode pin whose pending bit is still set is therefore delivered again.
- R11: When several pins are eligible in one cycle, the lowest-numbered pin is loaded first, one pin per cycle.
- R12: While `dlv_valid`=1 and `dlv_ready`=0, `dlv_valid`, `dlv_pin`, `dlv_vector`, `dlv_dest` and `dlv_level` hold their values.
- R13: A delivery carries the pin number, and the vector, destination and trigger mode (`dlv_level`=1 for level) of that pin's entry as it was when the pin was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | NUM_PINS | Raw interrupt line levels |
| cfg_we | input | 1 | Write strobe for one routing entry |
| cfg_pin | input | IDX_W | Entry index to write |
| cfg_vector | input | VEC_W | Vector field |
| cfg_dest | input | DEST_W | Destination field |
| cfg_polarity | input | 1 | 1 = line is active low |
| cfg_level | input | 1 | 1 = level mode, 0 = edge mode |
| cfg_mask | input | 1 | 1 = entry masked |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level-mode EOI |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Downstream accepts the message |
| dlv_pin | output | IDX_W | Pin that raised the message |
| dlv_vector | output | VEC_W | Vector of the message |
| dlv_dest | output | DEST_W | Destination of the message |
| dlv_level | output | 1 | Trigger mode of the message |
| coalesced | output | NUM_PINS | One-cycle pulse per pin for a dropped event |

## Verification
The hardest state to reach from the ports is an edge request that waits behind a stalled delivery port while its line toggles again. Only that situation shows the edge coalescing. The bench holds `dlv_ready` low after a first delivery fills the port. It then drops and raises the same line twice, so a second request queues and the third change collides with it. The other hard case is two level pins that share one vector and are both in service. A single level EOI then has to release both, and the bench checks that they come back in pin order.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_accept_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VEC_W-1:0]    wr_vec,
  input  logic [DEST_W-1:0]   wr_dest,
  input  logic                wr_pol,
  input  trig_e               wr_trig,
  input  logic                wr_mask,
  output logic [VEC_W-1:0]    vec_o  [NUM_PINS],
  output logic [DEST_W-1:0]   dest_o [NUM_PINS],
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] hit_o
);
  // One register set per entry; out-of-range indices hit nothing.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
    assign hit_o[p] = wr_en && (wr_idx == IDX_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_o[p]  <= '0;
        dest_o[p] <= '0;
        pol_o[p]  <= 1'b0;
        lvl_o[p]  <= TRIG_EDGE;
        mask_o[p] <= 1'b1;
      end else if (hit_o[p]) begin
        vec_o[p]  <= wr_vec;
        dest_o[p] <= wr_dest;
        pol_o[p]  <= wr_pol;
        lvl_o[p]  <= wr_trig;
        mask_o[p] <= wr_mask;
      end
    end
  end
endmodule

// File: rtl/irq_pin_track.sv
module irq_pin_track
  import irq_accept_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_raw,
  input  logic             pol,
  input  logic             lvl,
  input  logic             mask,
  input  logic [VEC_W-1:0] vec,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vec,
  input  logic             eoi_level,
  input  logic             rewrite,
  input  logic             issue,
  output logic             cand,
  output logic             coal,
  output logic             rirr
);
  logic eff, rise, pend_q, req_q, req_d, rirr_d, coal_d, eoi_hit;

  assign eff     = line_raw ^ pol;
  assign rise    = eff & ~pend_q;
  assign eoi_hit = eoi_valid && eoi_level && (eoi_vec == vec);

  // Edge requests queue until the pin is loaded; masking drops them.
  always_comb begin
    req_d = 1'b0;
    if (lvl == TRIG_EDGE && !mask)
      req_d = (req_q & ~issue) | rise;
  end

  // In-service flag for level pins: set on load, cleared by EOI or rewrite.
  always_comb begin
    rirr_d = rirr;
    if (eoi_hit || rewrite) rirr_d = 1'b0;
    if (issue && lvl == TRIG_LEVEL) rirr_d = 1'b1;
  end

  always_comb begin
    coal_d = 1'b0;
    if (!mask && rise)
      coal_d = (lvl == TRIG_LEVEL) ? rirr : (req_q & ~issue);
  end

  assign cand = ~mask & ((lvl == TRIG_LEVEL) ? (pend_q & ~rirr) : req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      rirr   <= 1'b0;
      coal   <= 1'b0;
    end else begin
      pend_q <= eff;
      req_q  <= req_d;
      rirr   <= rirr_d;
      coal   <= coal_d;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);
  // Scan from the top down so the lowest set bit is the last to land.
  always_comb begin
    any    = |req;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx    = IDX_W'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] line_in,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_pin,
  input  logic [VEC_W-1:0]    cfg_vector,
  input  logic [DEST_W-1:0]   cfg_dest,
  input  logic                cfg_polarity,
  input  logic                cfg_level,
  input  logic                cfg_mask,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  input  logic                eoi_level,
  output logic                dlv_valid,
  input  logic                dlv_ready,
  output logic [IDX_W-1:0]    dlv_pin,
  output logic [VEC_W-1:0]    dlv_vector,
  output logic [DEST_W-1:0]   dlv_dest,
  output logic                dlv_level,
  output logic [NUM_PINS-1:0] coalesced
);
  logic [VEC_W-1:0]    vec_tab  [NUM_PINS];
  logic [DEST_W-1:0]   dest_tab [NUM_PINS];
  logic [NUM_PINS-1:0] pol_tab, trig_tab, mask_tab, wr_hit;
  logic [NUM_PINS-1:0] cand_vec, rirr_vec, issue_vec, pick_onehot;
  logic [IDX_W-1:0]    pick_idx;
  logic                pick_any, slot_free, issue_any;

  irq_route_table #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .IDX_W(IDX_W)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_pin),
    .wr_vec (cfg_vector),
    .wr_dest(cfg_dest),
    .wr_pol (cfg_polarity),
    .wr_trig(trig_e'(cfg_level)),
    .wr_mask(cfg_mask),
    .vec_o  (vec_tab),
    .dest_o (dest_tab),
    .pol_o  (pol_tab),
    .lvl_o  (trig_tab),
    .mask_o (mask_tab),
    .hit_o  (wr_hit)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irq_pin_track #(.VEC_W(VEC_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (line_in[p]),
      .pol      (pol_tab[p]),
      .lvl      (trig_tab[p]),
      .mask     (mask_tab[p]),
      .vec      (vec_tab[p]),
      .eoi_valid(eoi_valid),
      .eoi_vec  (eoi_vector),
      .eoi_level(eoi_level),
      .rewrite  (wr_hit[p]),
      .issue    (issue_vec[p]),
      .cand     (cand_vec[p]),
      .coal     (coalesced[p]),
      .rirr     (rirr_vec[p])
    );
  end

  irq_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .req   (cand_vec),
    .any   (pick_any),
    .idx   (pick_idx),
    .onehot(pick_onehot)
  );

  // Output slot: reload whenever empty or being drained this cycle.
  assign slot_free = ~dlv_valid | dlv_ready;
  assign issue_any = slot_free & pick_any;
  assign issue_vec = slot_free ? pick_onehot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_valid  <= 1'b0;
      dlv_pin    <= '0;
      dlv_vector <= '0;
      dlv_dest   <= '0;
      dlv_level  <= 1'b0;
    end else if (slot_free) begin
      dlv_valid <= pick_any;
      if (pick_any) begin
        dlv_pin    <= pick_idx;
        dlv_vector <= vec_tab[pick_idx];
        dlv_dest   <= dest_tab[pick_idx];
        dlv_level  <= trig_tab[pick_idx];
      end
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dlv_valid,
  input logic                dlv_ready,
  input logic [IDX_W-1:0]    dlv_pin,
  input logic [VEC_W-1:0]    dlv_vector,
  input logic [DEST_W-1:0]   dlv_dest,
  input logic                dlv_level,
  input logic [NUM_PINS-1:0] coalesced,
  input logic                eoi_valid,
  input logic [VEC_W-1:0]    eoi_vector,
  input logic                eoi_level,
  input logic [VEC_W-1:0]    vec_tab [NUM_PINS],
  input logic [NUM_PINS-1:0] trig_tab,
  input logic [NUM_PINS-1:0] mask_tab,
  input logic [NUM_PINS-1:0] cand_vec,
  input logic [NUM_PINS-1:0] rirr_vec,
  input logic [NUM_PINS-1:0] issue_vec,
  input logic                issue_any,
  input logic [IDX_W-1:0]    pick_idx
);
  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin) &&
      $stable(dlv_vector) && $stable(dlv_dest) && $stable(dlv_level));

  assert_issue_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_any |-> !mask_tab[pick_idx]);

  assert_lowest_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_any |-> (cand_vec & ~({NUM_PINS{1'b1}} << pick_idx)) == '0);

  assert_level_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_any && trig_tab[pick_idx] |=> rirr_vec[$past(pick_idx)]);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    assert_eoi_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid && eoi_level && (eoi_vector == vec_tab[p]) && !issue_vec[p]
        |=> !rirr_vec[p]);

    assert_coal_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      coalesced[p] |=> !coalesced[p]);
  end
endmodule

bind irq_accept_unit irq_accept_chk #(
  .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dlv_valid (dlv_valid),
  .dlv_ready (dlv_ready),
  .dlv_pin   (dlv_pin),
  .dlv_vector(dlv_vector),
  .dlv_dest  (dlv_dest),
  .dlv_level (dlv_level),
  .coalesced (coalesced),
  .eoi_valid (eoi_valid),
  .eoi_vector(eoi_vector),
  .eoi_level (eoi_level),
  .vec_tab   (vec_tab),
  .trig_tab  (trig_tab),
  .mask_tab  (mask_tab),
  .cand_vec  (cand_vec),
  .rirr_vec  (rirr_vec),
  .issue_vec (issue_vec),
  .issue_any (issue_any),
  .pick_idx  (pick_idx)
);

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_in = 8'h00;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_pin = '0;
  logic [7:0] cfg_vector = '0, cfg_dest = '0;
  logic       cfg_polarity = 1'b0, cfg_level = 1'b0, cfg_mask = 1'b1;
  logic       eoi_valid = 1'b0, eoi_level = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic       dlv_valid, dlv_ready = 1'b1, dlv_level;
  logic [2:0] dlv_pin;
  logic [7:0] dlv_vector, dlv_dest, coalesced;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_vec  [8];
  logic [7:0] m_dest [8];
  logic       m_lvl  [8];

  always #4 clk = ~clk;

  irq_accept_unit u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_vector(cfg_vector),
    .cfg_dest(cfg_dest), .cfg_polarity(cfg_polarity), .cfg_level(cfg_level),
    .cfg_mask(cfg_mask), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
    .dlv_level(dlv_level), .coalesced(coalesced)
  );

  typedef struct packed {
    logic [7:0] line;
    logic       rdy;
    logic       ev;
    logic [7:0] evec;
    logic       elvl;
    logic       xv;
    logic [2:0] xpin;
    logic [7:0] xcoal;
  } row_t;

  // pin0 edge vec20, pin1 level vec31, pin2 level vec31, pin3 edge active-low vec40
  localparam row_t TBL [25] = '{
    '{8'h08,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00}, // idle
    '{8'h09,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00}, // R3 pin0 rises
    '{8'h09,1'b1,1'b0,8'h00,1'b0,1'b1,3'd0,8'h00}, // R3 delivered
    '{8'h09,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00}, // R3 held high, none
    '{8'h08,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00},
    '{8'h0A,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00}, // R5 pin1 active
    '{8'h0A,1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,8'h00}, // R5 delivered
    '{8'h0A,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00}, // R5 locked
    '{8'h08,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00},
    '{8'h0A,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h02}, // R6 coalesced
    '{8'h0A,1'b1,1'b1,8'h31,1'b1,1'b0,3'd0,8'h00}, // R7 level EOI
    '{8'h0A,1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,8'h00}, // R7 redelivered
    '{8'h0A,1'b1,1'b1,8'h31,1'b0,1'b0,3'd0,8'h00}, // R7 edge EOI no effect
    '{8'h0A,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00},
    '{8'h02,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00}, // R2 pin3 line low
    '{8'h02,1'b1,1'b0,8'h00,1'b0,1'b1,3'd3,8'h00}, // R2 delivered
    '{8'h0E,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00},
    '{8'h0E,1'b1,1'b0,8'h00,1'b0,1'b1,3'd2,8'h00}, // R5 pin2
    '{8'h0E,1'b1,1'b1,8'h31,1'b1,1'b0,3'd0,8'h00}, // R7 shared vector EOI
    '{8'h0E,1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,8'h00}, // R11 lower pin first
    '{8'h0E,1'b1,1'b0,8'h00,1'b0,1'b1,3'd2,8'h00}, // R11 then next
    '{8'h0E,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00},
    '{8'h08,1'b1,1'b1,8'h31,1'b1,1'b0,3'd0,8'h00}, // R8 EOI after drop
    '{8'h08,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00}, // R8 none
    '{8'h08,1'b1,1'b0,8'h00,1'b0,1'b0,3'd0,8'h00}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] l, input logic r, input logic ev,
                      input logic [7:0] evec, input logic elvl);
    @(negedge clk);
    cfg_we = 1'b0; line_in = l; dlv_ready = r;
    eoi_valid = ev; eoi_vector = evec; eoi_level = elvl;
    @(posedge clk); #2;
  endtask

  task automatic write_entry(input int p, input logic [7:0] v, input logic [7:0] d,
                             input logic pol, input logic lvl, input logic msk);
    @(negedge clk);
    eoi_valid = 1'b0;
    cfg_we = 1'b1; cfg_pin = 3'(p); cfg_vector = v; cfg_dest = d;
    cfg_polarity = pol; cfg_level = lvl; cfg_mask = msk;
    m_vec[p] = v; m_dest[p] = d; m_lvl[p] = lvl;
    @(posedge clk); #2;
  endtask

  task automatic expect_out(input logic xv, input logic [2:0] xpin, input string req);
    check(dlv_valid == xv, req, dlv_valid, xv);
    if (xv) begin
      check(dlv_pin == xpin, req, dlv_pin, xpin);
      check(dlv_vector == m_vec[xpin] && dlv_dest == m_dest[xpin] &&
            dlv_level == m_lvl[xpin], "R13",
            {dlv_vector, dlv_dest, 7'd0, dlv_level},
            {m_vec[xpin], m_dest[xpin], 7'd0, m_lvl[xpin]});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    line_in = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(dlv_valid == 1'b0 && coalesced == 8'h00, "R1", {dlv_valid, coalesced}, 0);
    // R1 masked after reset: active lines do nothing
    for (int i = 0; i < 4; i++) begin
      step(i[0] ? 8'hFF : 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
      check(dlv_valid == 1'b0 && coalesced == 8'h00, "R1", {dlv_valid, coalesced}, 0);
    end
    step(8'h08, 1'b1, 1'b0, 8'h00, 1'b0);
    write_entry(0, 8'h20, 8'h01, 1'b0, 1'b0, 1'b0);
    write_entry(1, 8'h31, 8'h02, 1'b0, 1'b1, 1'b0);
    write_entry(2, 8'h31, 8'h03, 1'b0, 1'b1, 1'b0);
    write_entry(3, 8'h40, 8'h04, 1'b1, 1'b0, 1'b0);
    step(8'h08, 1'b1, 1'b0, 8'h00, 1'b0);
    step(8'h08, 1'b1, 1'b0, 8'h00, 1'b0);

    for (int i = 0; i < 25; i++) begin
      step(TBL[i].line, TBL[i].rdy, TBL[i].ev, TBL[i].evec, TBL[i].elvl);
      expect_out(TBL[i].xv, TBL[i].xpin, $sformatf("row%0d R3/R5/R7/R11", i));
      check(coalesced == TBL[i].xcoal, "R6 coalesced", coalesced, TBL[i].xcoal);
    end

    // R12 / R4: stalled port, edge pin toggles twice more
    step(8'h09, 1'b0, 1'b0, 8'h00, 1'b0); expect_out(1'b0, 3'd0, "R3");
    step(8'h09, 1'b0, 1'b0, 8'h00, 1'b0); expect_out(1'b1, 3'd0, "R3");
    step(8'h09, 1'b0, 1'b0, 8'h00, 1'b0); expect_out(1'b1, 3'd0, "R12 hold");
    step(8'h08, 1'b0, 1'b0, 8'h00, 1'b0); expect_out(1'b1, 3'd0, "R12 hold");
    step(8'h09, 1'b0, 1'b0, 8'h00, 1'b0);
    check(coalesced == 8'h00, "R4 first queued", coalesced, 8'h00);
    step(8'h08, 1'b0, 1'b0, 8'h00, 1'b0);
    step(8'h09, 1'b0, 1'b0, 8'h00, 1'b0);
    check(coalesced == 8'h01, "R4 coalesced", coalesced, 8'h01);
    expect_out(1'b1, 3'd0, "R12 hold");
    step(8'h09, 1'b1, 1'b0, 8'h00, 1'b0); expect_out(1'b1, 3'd0, "R4 queued one");
    step(8'h09, 1'b1, 1'b0, 8'h00, 1'b0); expect_out(1'b0, 3'd0, "R4 only one");
    step(8'h08, 1'b1, 1'b0, 8'h00, 1'b0);

    // R9: masked edge pin
    write_entry(0, 8'h20, 8'h01, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(8'h09, 1'b1, 1'b0, 8'h00, 1'b0);
      expect_out(1'b0, 3'd0, "R9 masked");
      check(coalesced == 8'h00, "R9 no coalesce", coalesced, 8'h00);
    end
    step(8'h08, 1'b1, 1'b0, 8'h00, 1'b0);

    // R10: rewrite of an in-service level entry re-delivers
    step(8'h0A, 1'b1, 1'b0, 8'h00, 1'b0);
    step(8'h0A, 1'b1, 1'b0, 8'h00, 1'b0); expect_out(1'b1, 3'd1, "R10 setup");
    step(8'h0A, 1'b1, 1'b0, 8'h00, 1'b0); expect_out(1'b0, 3'd0, "R10 locked");
    write_entry(1, 8'h31, 8'h05, 1'b0, 1'b1, 1'b0);
    expect_out(1'b0, 3'd0, "R10 write cycle");
    step(8'h0A, 1'b1, 1'b0, 8'h00, 1'b0); expect_out(1'b1, 3'd1, "R10 redelivered");
    step(8'h08, 1'b1, 1'b0, 8'h00, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule